// File: doc/BRIEF.md
# Way-Predicted Four-Way Data Cache

This block is a data cache split into four ways that can each be switched on by
itself. It saves array energy by guessing the way first. A prediction table is
indexed by the instruction address of the load or store. It is read when the
request is accepted, before the data address takes part in the lookup. In the
first probe cycle, only the guessed way's tag and data arrays are active. A
match there answers at once.

When the guess is wrong, the second probe cycle enables the tags of the other
three ways. Only the data array of the way that matches is then read. The table
entry is rewritten with that way. When no way matches, a victim is chosen. An
invalid way is taken first, and otherwise a three-bit tree pseudo-LRU per set
decides. One line is fetched from the next level and installed, and the table
learns the victim way.

Each response carries the read word, a latency class, and the number of tag and
data array enables the access used. A bench or a power model can use these
counts to confirm that ways were activated sparingly.

Top module: `wpc_cache`

## Requirements
- R1: After reset, every line is invalid and every predictor entry holds way 0. `req_ready` is 1, `rsp_valid` is 0 and `fill_req_valid` is 0. The first access to any address misses.
- R2: The predictor has 1024 entries of 2 bits. It is indexed by `req_pc[11:2]` and read at acceptance, so two instruction addresses that differ only outside bits 11:2 share one entry.
- R3: When the predicted way holds the line, `rsp_valid` is 1 in the first cycle after acceptance. In that response, `rsp_lat` is 0, `rsp_tag_en` is 1 and `rsp_data_en` is 1.
- R4: When another way holds the line, `rsp_valid` is 1 in the second cycle after acceptance. In that response, `rsp_lat` is 1, `rsp_tag_en` is 4 and `rsp_data_en` is 2. The predictor entry then holds the way that hit.
- R5: On a miss, `fill_req_valid` is 1 from the third cycle after acceptance. `fill_req_addr` equals the request address with bits 1:0 cleared. Both stay unchanged until `fill_rsp_valid` is 1. In that same cycle the response appears with `rsp_lat` 2, `rsp_tag_en` 5 and `rsp_data_en` 2.
- R6: The victim is the lowest-numbered invalid way of the set. If the set has no invalid way, the tree bits {b2,b1,b0} choose: b0=0 selects way b1 (0 or 1), and b0=1 selects way 2+b2.
- R7: Every hit and every install touches the used way w. This sets b0 = (w<2). For w<2 it also sets b1 = (w==0); for w>=2 it sets b2 = (w==2). All tree bits are 0 after reset.
- R8: After a miss, the predictor entry of that instruction address holds the victim way.
- R9: A write hit stores `req_wdata` in the line. A write miss installs the line and then stores `req_wdata` over it. `rsp_rdata` is the line's word after the access: the write data for writes, the stored word for read hits, and `fill_rsp_data` for read misses.
- R10: `req_ready` is 1 only when no access is in flight. A request presented while `req_ready` is 0 is ignored and changes no line, predictor entry or tree bit.
- R11: The set index is `req_addr[5:2]` (16 sets), the tag is `req_addr[15:6]`, and bits 1:0 are ignored.
- R12: At most one data way is enabled in any cycle. The predicted way never matches during the second probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle, request accepted this cycle |
| req_pc | input | 32 | Instruction address of the memory operation |
| req_addr | input | 16 | Data byte address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_rdata | output | 32 | Line word after the access |
| rsp_lat | output | 2 | 0 first-probe hit, 1 second-probe hit, 2 miss |
| rsp_tag_en | output | 3 | Tag array enables used by this access |
| rsp_data_en | output | 3 | Data array enables used by this access |
| fill_req_valid | output | 1 | Line fetch request to the next level |
| fill_req_addr | output | 16 | Line address of the fetch |
| fill_rsp_valid | input | 1 | Fetched line present |
| fill_rsp_data | input | 32 | Fetched line word |

## Verification
The line install, the merge of store data, the predictor rewrite and the tree-bit touch all take effect at the single edge that closes a miss. Store misses and load misses under noise traffic drive all four updates into that one edge. The bench then judges each update only through later accesses: their latency class, data and enable counts must follow a behavioural model of table, tags and tree. Requests held high while the cache is busy land in the same cycles as probes and fills, and the model treats them as having no effect.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

   typedef enum logic [1:0] {
      LAT_FIRST  = 2'd0,
      LAT_SECOND = 2'd1,
      LAT_MISS   = 2'd2
   } lat_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PROBE1 = 2'd1,
      ST_PROBE2 = 2'd2,
      ST_FILL   = 2'd3
   } st_e;

   localparam int TREE_WAYS = 4;

   // tree bits: [0] root, [1] pair 0/1, [2] pair 2/3
   function automatic logic [1:0] tree_pick(input logic [2:0] b);
      return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
   endfunction

   function automatic logic [2:0] tree_touch(input logic [2:0] b, input logic [1:0] w);
      logic [2:0] n;
      n    = b;
      n[0] = ~w[1];
      if (w[1]) n[2] = ~w[0];
      else      n[1] = ~w[0];
      return n;
   endfunction

endpackage

// File: rtl/wpc_predictor.sv
module wpc_predictor #(
   parameter int ENTRIES = 1024,
   parameter int WAY_W   = 2,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [WAY_W-1:0] rd_way,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [WAY_W-1:0] wr_way
);

   if ((1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("predictor depth must be a power of two");
   end

   logic [WAY_W-1:0] table_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) table_q[i] <= '0;
      end else if (wr_en) begin
         table_q[wr_idx] <= wr_way;
      end
   end

   assign rd_way = table_q[rd_idx];

   // R2 / R4 / R8: a trained entry keeps the way it was given
   a_r8_entry_learned: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> table_q[$past(wr_idx)] == $past(wr_way));

endmodule

// File: rtl/wpc_ways.sv
module wpc_ways #(
   parameter int WAYS   = 4,
   parameter int SETS   = 16,
   parameter int TAG_W  = 10,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic [TAG_W-1:0]  tag,
   input  logic [WAYS-1:0]   tag_en,
   input  logic [WAYS-1:0]   data_en,
   input  logic              tag_we,
   input  logic              data_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [WAYS-1:0]   match,
   output logic [WAYS-1:0]   valid_set,
   output logic [DATA_W-1:0] rdata
);

   logic [WAYS-1:0]   raw_hit;
   logic [DATA_W-1:0] way_word [WAYS];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0]  tags_q  [SETS];
      logic [DATA_W-1:0] words_q [SETS];
      logic [SETS-1:0]   vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    vld_q      <= '0;
         else if (tag_we && tag_en[w])  vld_q[idx] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (tag_we && tag_en[w])   tags_q[idx]  <= tag;
         if (data_we && data_en[w]) words_q[idx] <= wdata;
      end

      assign raw_hit[w]   = vld_q[idx] && (tags_q[idx] == tag);
      assign match[w]     = tag_en[w] && raw_hit[w];
      assign valid_set[w] = vld_q[idx];
      assign way_word[w]  = data_en[w] ? words_q[idx] : '0;
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < WAYS; w++) rdata = rdata | way_word[w];
   end

   // R12: a single data way is active per cycle
   a_r12_one_data_way: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(data_en));

   // R11: a tag lives in at most one way of a set
   a_r11_unique_line: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(raw_hit));

endmodule

// File: rtl/wpc_repl.sv
module wpc_repl
   import wpc_pkg::*;
#(
   parameter int SETS   = 16,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [3:0]       valid_set,
   input  logic             touch_en,
   input  logic [1:0]       touch_way,
   output logic [1:0]       victim
);

   logic [2:0] tree_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
      end else if (touch_en) begin
         tree_q[idx] <= tree_touch(tree_q[idx], touch_way);
      end
   end

   always_comb begin
      victim = tree_pick(tree_q[idx]);
      for (int w = TREE_WAYS - 1; w >= 0; w--) begin
         if (!valid_set[w]) victim = 2'(w);
      end
   end

   // R7: after a touch the tree points away from the touched way
   a_r7_touch_points_away: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> tree_pick(tree_q[$past(idx)]) != $past(touch_way));

endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
   import wpc_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int PC_W         = 32,
   parameter int DATA_W       = 32,
   parameter int WAYS         = 4,
   parameter int SETS         = 16,
   parameter int PRED_ENTRIES = 1024,
   parameter int OFF_W        = 2,
   parameter int PC_LSB       = 2,
   localparam int CNT_W       = $clog2(WAYS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [PC_W-1:0]   req_pc,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [1:0]        rsp_lat,
   output logic [CNT_W-1:0]  rsp_tag_en,
   output logic [CNT_W-1:0]  rsp_data_en,
   output logic              fill_req_valid,
   output logic [ADDR_W-1:0] fill_req_addr,
   input  logic              fill_rsp_valid,
   input  logic [DATA_W-1:0] fill_rsp_data
);

   localparam int IDX_W   = $clog2(SETS);
   localparam int WAY_W   = $clog2(WAYS);
   localparam int PIDX_W  = $clog2(PRED_ENTRIES);
   localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
   localparam int LINE_W  = ADDR_W - OFF_W;

   if (WAYS != TREE_WAYS) begin : g_bad_ways
      $error("replacement tree is built for four ways");
   end
   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("set count must be a power of two");
   end
   if (TAG_W < 1 || PC_LSB + PIDX_W > PC_W) begin : g_bad_split
      $error("address split does not fit the port widths");
   end

   function automatic logic [CNT_W-1:0] ones(input logic [WAYS-1:0] v);
      logic [CNT_W-1:0] c;
      c = '0;
      for (int i = 0; i < WAYS; i++) c = c + CNT_W'(v[i]);
      return c;
   endfunction

   st_e               state, state_n;
   logic [PIDX_W-1:0] pidx_q;
   logic [LINE_W-1:0] line_q;
   logic              we_q;
   logic [DATA_W-1:0] wdata_q;
   logic [WAY_W-1:0]  pred_q, victim_q;
   logic [CNT_W-1:0]  tcnt_q, dcnt_q;

   logic [WAY_W-1:0]  pred_rd, hit_way, victim_c, touch_way, pw_way;
   logic [WAYS-1:0]   pred_oh, victim_oh, tag_en, data_en, match, valid_set;
   logic              tag_we, data_we, hit, touch_en, pw_en;
   logic [DATA_W-1:0] wr_word, way_rdata;
   logic [IDX_W-1:0]  set_idx;
   logic [TAG_W-1:0]  set_tag;
   logic              unused_bits;

   assign unused_bits = ^{req_pc[PC_W-1:PC_LSB+PIDX_W], req_pc[PC_LSB-1:0],
                          req_addr[OFF_W-1:0]};

   assign set_idx   = line_q[IDX_W-1:0];
   assign set_tag   = line_q[LINE_W-1:IDX_W];
   assign pred_oh   = WAYS'(1) << pred_q;
   assign victim_oh = WAYS'(1) << victim_q;

   wpc_predictor #(.ENTRIES(PRED_ENTRIES), .WAY_W(WAY_W)) u_pred (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (req_pc[PC_LSB +: PIDX_W]),
      .rd_way (pred_rd),
      .wr_en  (pw_en),
      .wr_idx (pidx_q),
      .wr_way (pw_way)
   );

   wpc_ways #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ways (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (set_idx),
      .tag       (set_tag),
      .tag_en    (tag_en),
      .data_en   (data_en),
      .tag_we    (tag_we),
      .data_we   (data_we),
      .wdata     (wr_word),
      .match     (match),
      .valid_set (valid_set),
      .rdata     (way_rdata)
   );

   wpc_repl #(.SETS(SETS)) u_repl (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (set_idx),
      .valid_set (valid_set),
      .touch_en  (touch_en),
      .touch_way (touch_way),
      .victim    (victim_c)
   );

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end

   always_comb begin
      state_n   = state;
      tag_en    = '0;
      data_en   = '0;
      tag_we    = 1'b0;
      data_we   = 1'b0;
      wr_word   = wdata_q;
      hit       = 1'b0;
      touch_en  = 1'b0;
      touch_way = pred_q;
      pw_en     = 1'b0;
      pw_way    = hit_way;
      rsp_valid = 1'b0;
      rsp_lat   = LAT_FIRST;
      rsp_rdata = we_q ? wdata_q : way_rdata;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) state_n = ST_PROBE1;
         end
         ST_PROBE1: begin
            tag_en  = pred_oh;
            data_en = pred_oh;
            hit     = |match;
            data_we = hit && we_q;
            if (hit) begin
               rsp_valid = 1'b1;
               touch_en  = 1'b1;
               state_n   = ST_IDLE;
            end else begin
               state_n   = ST_PROBE2;
            end
         end
         ST_PROBE2: begin
            tag_en  = ~pred_oh;
            data_en = match;
            hit     = |match;
            data_we = hit && we_q;
            if (hit) begin
               rsp_valid = 1'b1;
               rsp_lat   = LAT_SECOND;
               touch_en  = 1'b1;
               touch_way = hit_way;
               pw_en     = 1'b1;
               state_n   = ST_IDLE;
            end else begin
               state_n   = ST_FILL;
            end
         end
         ST_FILL: begin
            if (fill_rsp_valid) begin
               tag_en    = victim_oh;
               data_en   = victim_oh;
               tag_we    = 1'b1;
               data_we   = 1'b1;
               wr_word   = we_q ? wdata_q : fill_rsp_data;
               rsp_valid = 1'b1;
               rsp_lat   = LAT_MISS;
               rsp_rdata = wr_word;
               touch_en  = 1'b1;
               touch_way = victim_q;
               pw_en     = 1'b1;
               pw_way    = victim_q;
               state_n   = ST_IDLE;
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   assign rsp_tag_en     = tcnt_q + ones(tag_en);
   assign rsp_data_en    = dcnt_q + ones(data_en);
   assign req_ready      = (state == ST_IDLE);
   assign fill_req_valid = (state == ST_FILL);
   assign fill_req_addr  = {line_q, {OFF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pidx_q   <= '0;
         line_q   <= '0;
         we_q     <= 1'b0;
         wdata_q  <= '0;
         pred_q   <= '0;
         victim_q <= '0;
         tcnt_q   <= '0;
         dcnt_q   <= '0;
      end else begin
         state <= state_n;
         if (state == ST_IDLE && req_valid) begin
            pidx_q  <= req_pc[PC_LSB +: PIDX_W];
            line_q  <= req_addr[ADDR_W-1:OFF_W];
            we_q    <= req_write;
            wdata_q <= req_wdata;
            pred_q  <= pred_rd;
            tcnt_q  <= '0;
            dcnt_q  <= '0;
         end else if (state != ST_IDLE) begin
            tcnt_q <= rsp_tag_en;
            dcnt_q <= rsp_data_en;
         end
         if (state == ST_PROBE2 && !hit) victim_q <= victim_c;
      end
   end

   // R10: one access in flight, idle again after its answer
   a_r10_idle_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);

   // R3: a first-probe hit used one tag and one data array
   a_r3_first_probe_cost: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_lat == LAT_FIRST) |-> (rsp_tag_en == 1 && rsp_data_en == 1));

   // R5: a miss answer coincides with the fetched line
   a_r5_miss_with_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_lat == LAT_MISS) |-> (fill_req_valid && fill_rsp_valid));

   // R5: the fetch request holds still while it waits
   a_r5_fill_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req_valid && !fill_rsp_valid) |=> (fill_req_valid && $stable(fill_req_addr)));

   // R12: the predicted way cannot match in the second probe
   a_r12_pred_way_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROBE2) |-> !match[pred_q]);

endmodule

// File: tb/tb_wpc_cache.sv
module tb_wpc_cache;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_pc = '0;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [1:0]  rsp_lat;
   logic [2:0]  rsp_tag_en;
   logic [2:0]  rsp_data_en;
   logic        fill_req_valid;
   logic [15:0] fill_req_addr;
   logic        fill_rsp_valid = 1'b0;
   logic [31:0] fill_rsp_data = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wpc_cache dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_ready      (req_ready),
      .req_pc         (req_pc),
      .req_addr       (req_addr),
      .req_write      (req_write),
      .req_wdata      (req_wdata),
      .rsp_valid      (rsp_valid),
      .rsp_rdata      (rsp_rdata),
      .rsp_lat        (rsp_lat),
      .rsp_tag_en     (rsp_tag_en),
      .rsp_data_en    (rsp_data_en),
      .fill_req_valid (fill_req_valid),
      .fill_req_addr  (fill_req_addr),
      .fill_rsp_valid (fill_rsp_valid),
      .fill_rsp_data  (fill_rsp_data)
   );

   int checks = 0;
   int errors = 0;
   int gen = 0;

   // behavioural model
   bit          m_val  [16][4];
   int          m_tag  [16][4];
   logic [31:0] m_dat  [16][4];
   int          m_pred [1024];
   int          m_tree [16][3];

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int tree_victim(input int s);
      return (m_tree[s][0] == 0) ? m_tree[s][1] : 2 + m_tree[s][2];
   endfunction

   task automatic tree_use(input int s, input int w);
      m_tree[s][0] = (w < 2) ? 1 : 0;
      if (w < 2) m_tree[s][1] = (w == 0) ? 1 : 0;
      else       m_tree[s][2] = (w == 2) ? 1 : 0;
   endtask

   task automatic access(input logic [31:0] pc, input logic [15:0] addr, input bit wr,
                         input logic [31:0] wd, input int fdel, input bit noise);
      int s, tg, pi, p, path, w, v;
      logic [31:0] fd;
      s  = int'(addr[5:2]);
      tg = int'(addr[15:6]);
      pi = int'(pc[11:2]);
      p  = m_pred[pi];
      path = 2; w = -1; v = -1;
      if (m_val[s][p] && m_tag[s][p] == tg) begin
         path = 0; w = p;
      end else begin
         for (int k = 0; k < 4; k++)
            if (k != p && m_val[s][k] && m_tag[s][k] == tg) begin path = 1; w = k; end
      end
      if (path == 2) begin
         for (int k = 3; k >= 0; k--) if (!m_val[s][k]) v = k;
         if (v < 0) v = tree_victim(s);
      end
      gen++;
      fd = {addr & 16'hFFFC, 16'(gen)};

      @(negedge clk);
      chk("R10 ready while idle", 32'(req_ready), 32'd1);
      chk("R10 no response while idle", 32'(rsp_valid), 32'd0);
      req_valid = 1'b1; req_pc = pc; req_addr = addr; req_write = wr; req_wdata = wd;
      @(negedge clk);
      if (noise) begin
         req_pc = pc ^ 32'h0000_0FF0; req_addr = addr ^ 16'h0F00;
         req_write = 1'b1; req_wdata = ~wd;
      end else begin
         req_valid = 1'b0;
      end
      chk("R10 not ready while busy", 32'(req_ready), 32'd0);
      if (path == 0) begin
         chk("R3 first-probe response", 32'(rsp_valid), 32'd1);
         chk("R3 latency class", 32'(rsp_lat), 32'd0);
         chk("R3 tag enables", 32'(rsp_tag_en), 32'd1);
         chk("R3 data enables", 32'(rsp_data_en), 32'd1);
         chk("R9 hit data", rsp_rdata, wr ? wd : m_dat[s][w]);
         req_valid = 1'b0;
         tree_use(s, w);
         if (wr) m_dat[s][w] = wd;
         return;
      end
      chk("R3 no first-probe response on mispredict", 32'(rsp_valid), 32'd0);
      @(negedge clk);
      if (path == 1) begin
         chk("R4 second-probe response", 32'(rsp_valid), 32'd1);
         chk("R4 latency class", 32'(rsp_lat), 32'd1);
         chk("R4 tag enables", 32'(rsp_tag_en), 32'd4);
         chk("R4 data enables", 32'(rsp_data_en), 32'd2);
         chk("R9 hit data", rsp_rdata, wr ? wd : m_dat[s][w]);
         req_valid = 1'b0;
         tree_use(s, w);
         m_pred[pi] = w;
         if (wr) m_dat[s][w] = wd;
         return;
      end
      chk("R5 no response before fill", 32'(rsp_valid), 32'd0);
      chk("R5 no fetch in second probe", 32'(fill_req_valid), 32'd0);
      @(negedge clk);
      chk("R5 fetch raised", 32'(fill_req_valid), 32'd1);
      chk("R5 fetch address", 32'(fill_req_addr), 32'(addr & 16'hFFFC));
      for (int d = 0; d < fdel; d++) begin
         chk("R5 no response while fetching", 32'(rsp_valid), 32'd0);
         @(negedge clk);
         chk("R5 fetch held", 32'(fill_req_valid), 32'd1);
      end
      fill_rsp_valid = 1'b1; fill_rsp_data = fd;
      #1;
      chk("R5 miss response", 32'(rsp_valid), 32'd1);
      chk("R5 latency class", 32'(rsp_lat), 32'd2);
      chk("R5 tag enables", 32'(rsp_tag_en), 32'd5);
      chk("R5 data enables", 32'(rsp_data_en), 32'd2);
      chk("R9 miss data", rsp_rdata, wr ? wd : fd);
      req_valid = 1'b0;
      @(negedge clk);
      fill_rsp_valid = 1'b0; fill_rsp_data = '0;
      m_val[s][v] = 1'b1; m_tag[s][v] = tg; m_dat[s][v] = wr ? wd : fd;
      tree_use(s, v);
      m_pred[pi] = v;
   endtask

   initial begin
      for (int s = 0; s < 16; s++)
         for (int k = 0; k < 4; k++) begin
            m_val[s][k] = 1'b0; m_tag[s][k] = 0; m_dat[s][k] = '0;
            if (k < 3) m_tree[s][k] = 0;
         end
      for (int i = 0; i < 1024; i++) m_pred[i] = 0;

      repeat (3) @(negedge clk);
      chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R1 reset fetch idle", 32'(fill_req_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", 32'(req_ready), 32'd1);

      access(32'h100, 16'h0040, 0, 0, 1, 0);          // R1 cold miss, R6 way 0
      access(32'h100, 16'h0040, 0, 0, 0, 0);          // R3
      access(32'h100, 16'h0080, 0, 0, 0, 0);          // R8 predictor learns way 1
      access(32'h100, 16'h0042, 0, 0, 0, 0);          // R4, R11 offset ignored
      access(32'h1100, 16'h0040, 0, 0, 0, 0);         // R2 alias on bits 11:2
      access(32'h200, 16'h00C0, 0, 0, 2, 0);
      access(32'h200, 16'h0100, 0, 0, 0, 0);
      access(32'h300, 16'h0140, 0, 0, 1, 0);          // R6 R7 full set
      access(32'h300, 16'h0080, 1, 32'hDEAD_BEEF, 0, 0); // R9 write
      access(32'h300, 16'h0080, 0, 0, 0, 0);
      access(32'h400, 16'h004C, 1, 32'h1234_5678, 2, 0); // R9 write miss
      access(32'h400, 16'h004C, 0, 0, 0, 0);
      access(32'h500, 16'h0088, 0, 0, 1, 1);          // R10 noise while busy
      access(32'h500, 16'h0F88, 0, 0, 0, 1);          // noise address never installed
      for (int n = 0; n < 120; n++) begin
         logic [31:0] r;
         r = $urandom;
         access({20'h0, 2'(r[1:0]), 8'h0, 2'b00} | 32'h40,
                {4'h0, 6'(r[4:2] + 3'd1), 4'(r[6:5]), 2'(r[8:7])},
                r[9], $urandom, int'(r[11:10]), r[12]);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule